// File: doc/BRIEF.md
# CAN acceptance mask filter

This block decides whether a received CAN frame belongs to one message buffer. When the receiver finishes a frame, it presents the arbitration fields of that frame and strobes a completion input. The block then compares those fields with the identifier stored in the buffer. A programmable basic mask controls the comparison: any bit marked as don't-care is skipped. The block reports whether the frame was accepted. It also produces the identifier words the buffer should hold afterwards, with each don't-care position taken from the received frame.

The buffer identifier and the mask share one 32-bit layout, split into an upper and a lower 16-bit half. The layout depends on the frame type:

| Frame type | Upper half, bits 15:5 | Upper bit 4 | Upper bit 3 | Upper bits 2:0 | Lower bits 15:1 | Lower bit 0 |
|---|---|---|---|---|---|---|
| Extended | identifier bits 28:18 | SRR | frame-format bit | identifier bits 17:15 | identifier bits 14:0 | RTR |
| Standard | identifier bits 10:0 | RTR | frame-format bit | unused | unused | unused |

The mask is written as two 16-bit halves through a small write-only register port.

Top module: `can_mask_filter`

## Requirements
- R1: After reset both mask halves are zero, so only a frame whose compared bits all equal the stored bits is accepted.
- R2: A write with `mask_sel`=0 loads the upper mask half and a write with `mask_sel`=1 loads the lower half. The new value applies to frames strobed in any later cycle, and the mask holds its value when no write occurs.
- R3: `res_valid` is high for exactly the one cycle after a cycle in which `frm_done` is high, and low otherwise. `res_accept`, `res_hi` and `res_lo` change only with that pulse.
- R4: A compared bit whose mask bit is 0 must equal the stored bit; a single mismatch rejects the frame.
- R5: A compared bit whose mask bit is 1 is don't-care and never causes a rejection.
- R6: For an extended frame (`frm_ext`=1), all 32 bits are compared. Upper bits 15:5 are identifier bits 28:18, upper bit 4 is SRR, upper bit 3 is the frame-format bit (1 for this frame type), and upper bits 2:0 are identifier bits 17:15. Lower bits 15:1 are identifier bits 14:0 and lower bit 0 is RTR.
- R7: For a standard frame (`frm_ext`=0), only upper bits 15:3 are compared. Upper bits 15:5 are identifier bits 10:0, upper bit 4 is RTR and upper bit 3 is the frame-format bit (0 for this frame type). Identifier bits 28:11, `frm_srr`, upper bits 2:0 and the lower half do not affect acceptance.
- R8: On acceptance, every compared bit whose mask bit is 1 takes the received value in `res_hi`/`res_lo`. Every other bit keeps the stored value.
- R9: For a standard frame, upper bits 2:0 and the whole lower half of the result always equal the stored buffer bits.
- R10: On rejection, `res_hi`/`res_lo` equal the stored buffer words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_wr | input | 1 | Mask write strobe |
| mask_sel | input | 1 | Half select: 0 upper, 1 lower |
| mask_wdata | input | 16 | Mask write data |
| frm_done | input | 1 | Received frame complete |
| frm_ext | input | 1 | Received frame uses the extended format |
| frm_id | input | 29 | Received identifier (standard frames use bits 10:0) |
| frm_srr | input | 1 | Received SRR bit |
| frm_rtr | input | 1 | Received RTR bit |
| buf_hi | input | 16 | Stored buffer identifier, upper half |
| buf_lo | input | 16 | Stored buffer identifier, lower half |
| res_valid | output | 1 | Result pulse |
| res_accept | output | 1 | Frame accepted |
| res_hi | output | 16 | Updated identifier, upper half |
| res_lo | output | 16 | Updated identifier, lower half |

## Verification
The hardest case to reach is acceptance under a partly masked compare. Random frames against a random buffer almost never match on every unmasked bit, so acceptance and write-back would go untested. To reach it, the stimulus builds each frame from the stored buffer by decoding it back into identifier, SRR and RTR fields. It then flips a sparse set of bits and pairs the frame with masks that cover some or all of the flipped positions. Separate patterns set the stored frame-format bit against the frame type, and cover standard frames whose unused stored bits are random.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int ID_W      = 29;
    localparam int STD_ID_W  = 11;
    localparam int STD_CMP_W = STD_ID_W + 2;
    localparam int STD_LSB   = WORD_W - STD_CMP_W;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } mask_t;

    typedef struct packed {
        logic              valid;
        logic              accept;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } res_t;
endpackage

// File: rtl/can_filt_mask_regs.sv
module can_filt_mask_regs
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [HALF_W-1:0] wdata,
    output logic [WORD_W-1:0] mask_word
);
    mask_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr) begin
            if (sel) m_d.lo = wdata;
            else     m_d.hi = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign mask_word = m_q;
endmodule

// File: rtl/can_filt_frame_pack.sv
module can_filt_frame_pack
    import can_filt_pkg::*;
(
    input  logic              ext,
    input  logic [ID_W-1:0]   id,
    input  logic              srr,
    input  logic              rtr,
    output logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] used
);
    always_comb begin
        if (ext) begin
            in_word = {id[28:18], srr, 1'b1, id[17:15], id[14:0], rtr};
            used    = '1;
        end else begin
            in_word = {id[STD_ID_W-1:0], rtr, 1'b0, {STD_LSB{1'b0}}};
            used    = {{STD_CMP_W{1'b1}}, {STD_LSB{1'b0}}};
        end
    end
endmodule

// File: rtl/can_filt_bit_cmp.sv
module can_filt_bit_cmp
    import can_filt_pkg::*;
(
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] buf_word,
    input  logic [WORD_W-1:0] mask_word,
    input  logic [WORD_W-1:0] used,
    output logic              hit,
    output logic [WORD_W-1:0] new_word
);
    logic [WORD_W-1:0] ok;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        logic take;
        assign take        = used[i] & mask_word[i];
        assign ok[i]       = ~used[i] | mask_word[i] | (in_word[i] == buf_word[i]);
        assign new_word[i] = take ? in_word[i] : buf_word[i];
    end

    assign hit = &ok;
endmodule

// File: rtl/can_mask_filter.sv
module can_mask_filter
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic              mask_sel,
    input  logic [15:0]       mask_wdata,
    input  logic              frm_done,
    input  logic              frm_ext,
    input  logic [28:0]       frm_id,
    input  logic              frm_srr,
    input  logic              frm_rtr,
    input  logic [15:0]       buf_hi,
    input  logic [15:0]       buf_lo,
    output logic              res_valid,
    output logic              res_accept,
    output logic [15:0]       res_hi,
    output logic [15:0]       res_lo
);
    logic [WORD_W-1:0] mask_word, in_word, used, new_word, buf_word;
    logic [HALF_W-1:0] mask_hi, mask_lo;
    logic              hit;
    res_t              st_d, st_q;

    assign buf_word = {buf_hi, buf_lo};
    assign mask_hi  = mask_word[WORD_W-1:HALF_W];
    assign mask_lo  = mask_word[HALF_W-1:0];

    can_filt_mask_regs u_mask (
        .clk(clk), .rst_n(rst_n), .wr(mask_wr), .sel(mask_sel),
        .wdata(mask_wdata), .mask_word(mask_word)
    );

    can_filt_frame_pack u_pack (
        .ext(frm_ext), .id(frm_id), .srr(frm_srr), .rtr(frm_rtr),
        .in_word(in_word), .used(used)
    );

    can_filt_bit_cmp u_cmp (
        .in_word(in_word), .buf_word(buf_word), .mask_word(mask_word),
        .used(used), .hit(hit), .new_word(new_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = frm_done;
        if (frm_done) begin
            st_d.accept = hit;
            if (hit) {st_d.hi, st_d.lo} = new_word;
            else     {st_d.hi, st_d.lo} = buf_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.valid;
    assign res_accept = st_q.accept;
    assign res_hi     = st_q.hi;
    assign res_lo     = st_q.lo;
endmodule

// File: rtl/can_mask_filter_chk.sv
module can_mask_filter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mask_wr,
    input logic        frm_done,
    input logic        frm_ext,
    input logic [15:0] buf_hi,
    input logic [15:0] buf_lo,
    input logic [15:0] mask_hi,
    input logic [15:0] mask_lo,
    input logic        res_valid,
    input logic        res_accept,
    input logic [15:0] res_hi,
    input logic [15:0] res_lo
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> res_valid); // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> !res_valid); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> ($stable(res_accept) && $stable(res_hi) && $stable(res_lo))); // R3
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> ($stable(mask_hi) && $stable(mask_lo))); // R2
    AST_REJECT_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_accept) |-> ({res_hi, res_lo} == $past({buf_hi, buf_lo}))); // R10
    AST_STD_TAIL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(frm_ext)) |->
        (res_lo == $past(buf_lo) && res_hi[2:0] == $past(buf_hi[2:0]))); // R9
    AST_EXACT_NO_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(mask_hi) == 16'h0 && $past(mask_lo) == 16'h0) |->
        ({res_hi, res_lo} == $past({buf_hi, buf_lo}))); // R4
endmodule

bind can_mask_filter can_mask_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .frm_done(frm_done),
    .frm_ext(frm_ext), .buf_hi(buf_hi), .buf_lo(buf_lo),
    .mask_hi(mask_hi), .mask_lo(mask_lo), .res_valid(res_valid),
    .res_accept(res_accept), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/can_mask_filter_tb.sv
module can_mask_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_wr = 1'b0, mask_sel = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        frm_done = 1'b0, frm_ext = 1'b0, frm_srr = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [15:0] buf_hi = '0, buf_lo = '0;
    logic        res_valid, res_accept;
    logic [15:0] res_hi, res_lo;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    can_mask_filter u_dut (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_sel(mask_sel),
        .mask_wdata(mask_wdata), .frm_done(frm_done), .frm_ext(frm_ext),
        .frm_id(frm_id), .frm_srr(frm_srr), .frm_rtr(frm_rtr),
        .buf_hi(buf_hi), .buf_lo(buf_lo), .res_valid(res_valid),
        .res_accept(res_accept), .res_hi(res_hi), .res_lo(res_lo)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [32:0] ref_filter(input logic [31:0] m, input logic [31:0] b,
        input logic ext, input logic [28:0] id, input logic srr, input logic rtr);
        logic [31:0] w, u, upd;
        logic        ok;
        if (ext) begin
            w = {id[28:18], srr, 1'b1, id[17:15], id[14:0], rtr};
            u = 32'hFFFF_FFFF;
        end else begin
            w = {id[10:0], rtr, 1'b0, 19'd0};
            u = 32'hFFF8_0000;
        end
        ok  = (((~(w ^ b)) | m | ~u) == 32'hFFFF_FFFF);
        upd = ok ? ((b & ~(m & u)) | (w & m & u)) : b;
        return {ok, upd};
    endfunction

    task automatic chk(input logic [32:0] act, input logic [32:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_mask(input logic sel, input logic [15:0] d);
        @(negedge clk);
        mask_wr = 1'b1; mask_sel = sel; mask_wdata = d;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic send(input logic ext, input logic [28:0] id, input logic srr,
                        input logic rtr, input logic [31:0] b);
        @(negedge clk);
        frm_done = 1'b1; frm_ext = ext; frm_id = id; frm_srr = srr; frm_rtr = rtr;
        {buf_hi, buf_lo} = b;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    task automatic run_case(input logic [31:0] m, input logic [31:0] b, input logic ext,
                            input logic [28:0] id, input logic srr, input logic rtr,
                            input string tag);
        logic [32:0] e;
        e = ref_filter(m, b, ext, id, srr, rtr);
        send(ext, id, srr, rtr, b);
        chk({32'd0, res_valid}, 33'd1, "R3 valid pulse");
        chk({res_accept, res_hi, res_lo}, e, tag);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] b, m, fl;
        logic [28:0] id;
        logic        ext, srr, rtr;
        repeat (3) @(negedge clk);
        chk({res_valid, res_accept, res_hi, res_lo}, 34'd0, "R3 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        chk({32'd0, res_valid}, 33'd0, "R3 idle no valid");

        // R1: reset mask demands exact match
        b = {11'h5A3, 1'b1, 1'b1, 3'h5, 15'h1234, 1'b0};
        run_case(32'h0, b, 1'b1, {11'h5A3, 3'h5, 15'h1234}, 1'b1, 1'b0, "R1 exact accept");
        run_case(32'h0, b, 1'b1, {11'h5A3, 3'h5, 15'h1235}, 1'b1, 1'b0, "R1 one bit reject");
        @(negedge clk);
        chk({32'd0, res_valid}, 33'd0, "R3 single cycle pulse");
        chk({res_accept, res_hi, res_lo}, {1'b0, b}, "R3 result held");

        // R2: lower half write masks the RTR position only
        wr_mask(1'b1, 16'h0001);
        run_case(32'h0000_0001, b, 1'b1, {11'h5A3, 3'h5, 15'h1234}, 1'b1, 1'b1, "R2 lower write R8");
        wr_mask(1'b0, 16'h8000);
        run_case(32'h8000_0001, b, 1'b1, {11'h1A3, 3'h5, 15'h1234}, 1'b1, 1'b0, "R2 upper write R5");

        // R7: standard frame ignores high id bits and SRR
        b = {11'h3C1, 1'b0, 1'b0, 3'h7, 16'hBEEF};
        wr_mask(1'b0, 16'h0000); wr_mask(1'b1, 16'hFFFF);
        run_case(32'h0000_FFFF, b, 1'b0, {18'h2AAAA, 11'h3C1}, 1'b1, 1'b0, "R7 std ignore R9");

        for (int t = 0; t < 1500; t++) begin
            b  = rnd();
            ext = rnd() & 1;
            if (t % 5 != 0) b[19] = ext;
            case (t % 6)
                0: m = 32'h0;
                1: m = 32'hFFFF_FFFF;
                2: m = rnd();
                3: m = rnd() & rnd();
                4: m = 32'hFFE0_0000;
                default: m = 32'h1 << (rnd() % 32);
            endcase
            fl = (t % 3 == 0) ? 32'h0 : (rnd() & rnd() & rnd());
            if (t % 4 == 1) fl = fl & m;
            if (ext) begin
                id  = {b[31:21], b[18:16], b[15:1]};
                srr = b[20]; rtr = b[0];
                id  = id ^ {fl[31:21], fl[18:16], fl[15:1]};
                srr = srr ^ fl[20]; rtr = rtr ^ fl[0];
            end else begin
                id  = {rnd() % 18'h3FFFF, b[31:21] ^ fl[31:21]};
                rtr = b[20] ^ fl[20]; srr = rnd() & 1;
            end
            wr_mask(1'b0, m[31:16]);
            wr_mask(1'b1, m[15:0]);
            run_case(m, b, ext, id, srr, rtr,
                     ext ? "R6 ext sweep R4 R5 R8 R10" : "R7 std sweep R4 R5 R8 R9 R10");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule